// File: doc/BRIEF.md
# Mode-Tagged Indirect Branch Target Predictor

This block predicts the target of indirect branches for a core that runs two logical threads. A direct-mapped table, indexed by the low word-address bits of the branch PC, holds one learned target per slot. Each slot also records a partial PC tag, the thread that wrote it and the privilege-based predictor mode that thread was in. Only indirect calls, indirect jumps and returns may read or write the table. A lookup gives a registered target and a valid flag in the next cycle.

Each thread has three control bits. With restrict-speculation set, a lookup from that thread ignores any slot that was trained in a lower-ranked mode. With single-thread isolation set, a lookup from that thread ignores any slot written by the sibling thread. A barrier command from either thread empties the whole table, so no training done before it can steer a later lookup. Only the two sibling threads of this core have training ports. No other core can write the table.

A two-state controller tracks whether the table may hold live training. It has two states. EMPTY is entered at reset and on any barrier. LIVE is entered from EMPTY when training is accepted outside a barrier cycle. A barrier moves LIVE back to EMPTY. In EMPTY, and in any barrier cycle, no prediction is granted.

Top module: `modetag_ibp`

## Requirements
- R1: After reset, pred_valid is 0 and pred_target is 0, and a lookup to any address returns no prediction until training occurs.
- R2: An accepted training update, with a class that is not 00, becomes visible from the next cycle onward. A later lookup with the same index PC[5:2] and tag PC[13:6], whose filters pass, raises pred_valid with the trained target one cycle after the lookup cycle. Branch class is a 2-bit code: 00 not eligible, 01 indirect call, 10 indirect jump, 11 return.
- R3: A lookup whose index matches but whose tag PC[13:6] differs gives no prediction. A new training update to an index replaces the entry held there.
- R4: A lookup with class 00 always gives pred_valid 0. A training update with class 00 leaves the table unchanged.
- R5: The predictor mode is a 2-bit code: 00 host-supervisor, 01 host-user, 10 guest-supervisor, 11 guest-user. The privilege rank runs from 00 (highest) down to 11 (lowest), so guest modes rank below host modes and user below supervisor. When restrict-speculation is set for the looking-up thread, an entry trained in a lower-ranked mode gives no prediction. An entry trained in an equal or higher rank still predicts.
- R6: When restrict-speculation is clear for the looking-up thread, the training mode of an entry does not affect its prediction.
- R7: When single-thread isolation is set for the looking-up thread, an entry trained by the other thread gives no prediction, and an entry trained by the same thread does. When isolation is clear, entries are shared between the threads.
- R8: The restrict and isolation bits are indexed by thread ID (bit 0 for thread 0, bit 1 for thread 1). Each bit affects only lookups from its own thread.
- R9: A barrier bit from either thread invalidates every entry in the same cycle. A lookup in the barrier cycle gives no prediction. Training in the barrier cycle is discarded. Lookups afterwards miss until the table is trained again.
- R10: When training and lookup hit the same entry in the same cycle, the lookup sees the contents before that update.
- R11: pred_target is 0 whenever pred_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | 32 | Lookup branch address |
| lk_class | input | 2 | Lookup branch class |
| lk_tid | input | 1 | Looking-up thread |
| lk_mode | input | 2 | Predictor mode of the lookup |
| tr_valid | input | 1 | Training update present |
| tr_pc | input | 32 | Trained branch address |
| tr_target | input | 32 | Resolved target |
| tr_class | input | 2 | Trained branch class |
| tr_tid | input | 1 | Training thread |
| tr_mode | input | 2 | Predictor mode at training |
| restrict_spec | input | 2 | Per-thread restrict-speculation |
| iso_thread | input | 2 | Per-thread single-thread isolation |
| barrier_cmd | input | 2 | Per-thread barrier command |
| pred_valid | output | 1 | Prediction valid |
| pred_target | output | 32 | Predicted target |

## Verification
A prediction is due one cycle after its lookup cycle, because the output is registered. A training update is visible to lookups from the following cycle. A barrier acts on the lookup of its own cycle, so the cleared result is due one cycle later. The bench drives every input on a falling edge. It then reads the registered result at the next falling edge, after exactly one rising edge has passed. This keeps each check on the cycle in which its result is due.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    typedef enum logic [1:0] {
        M_HOST_SUP  = 2'b00,
        M_HOST_USR  = 2'b01,
        M_GUEST_SUP = 2'b10,
        M_GUEST_USR = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'b00,
        BC_ICALL = 2'b01,
        BC_IJMP  = 2'b10,
        BC_RET   = 2'b11
    } bclass_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_LIVE  = 1'b1
    } ctl_state_e;

    // Higher value means more privileged: guest below host, user below supervisor.
    function automatic logic [1:0] mode_rank(input logic [1:0] m);
        return ~m;
    endfunction

    function automatic logic class_ok(input logic [1:0] c);
        return c != BC_NONE;
    endfunction

endpackage

// File: rtl/ibp_table.sv
module ibp_table #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 8,
    parameter int TGT_W   = 32,
    parameter int TID_W   = 1,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ENT_W  = 1 + TAG_W + TGT_W + 2 + TID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [TGT_W-1:0]   wr_tgt,
    input  logic [1:0]         wr_mode,
    input  logic [TID_W-1:0]   wr_tid,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [TGT_W-1:0]   rd_tgt,
    output logic [1:0]         rd_mode,
    output logic [TID_W-1:0]   rd_tid,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENT_W-1:0] ent_bus [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic             v_q;
        logic [TAG_W-1:0] tag_q;
        logic [TGT_W-1:0] tgt_q;
        logic [1:0]       mode_q;
        logic [TID_W-1:0] tid_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (clear) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && !clear) begin
                tag_q  <= wr_tag;
                tgt_q  <= wr_tgt;
                mode_q <= wr_mode;
                tid_q  <= wr_tid;
            end
        end

        assign ent_bus[i]   = {v_q, tag_q, tgt_q, mode_q, tid_q};
        assign valid_vec[i] = v_q;
    end

    always_comb begin
        {rd_valid, rd_tag, rd_tgt, rd_mode, rd_tid} = ent_bus[rd_idx];
    end

    // R2: an accepted write leaves its slot valid in the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> valid_vec[$past(wr_idx)]);

endmodule

// File: rtl/ibp_filter.sv
module ibp_filter #(
    parameter int TAG_W   = 8,
    parameter int THREADS = 2,
    localparam int TID_W  = $clog2(THREADS)
) (
    input  logic               ent_valid,
    input  logic [TAG_W-1:0]   ent_tag,
    input  logic [1:0]         ent_mode,
    input  logic [TID_W-1:0]   ent_tid,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [1:0]         lk_mode,
    input  logic [TID_W-1:0]   lk_tid,
    input  logic [THREADS-1:0] restrict_vec,
    input  logic [THREADS-1:0] iso_vec,
    output logic               allow
);
    import ibp_pkg::*;

    logic [THREADS-1:0] mode_blk_t;
    logic [THREADS-1:0] thr_blk_t;
    logic               tag_hit;

    // Each thread's own controls judge the entry as if that thread were looking up.
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        assign mode_blk_t[t] = restrict_vec[t] &&
                               (mode_rank(ent_mode) < mode_rank(lk_mode));
        assign thr_blk_t[t]  = iso_vec[t] && (ent_tid != TID_W'(t));
    end

    always_comb begin
        tag_hit = ent_valid && (ent_tag == lk_tag);
        allow   = tag_hit && !mode_blk_t[lk_tid] && !thr_blk_t[lk_tid];
    end

endmodule

// File: rtl/ibp_ctrl.sv
module ibp_ctrl #(
    parameter int TGT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                barrier,
    input  logic                train_ok,
    input  logic                lk_fire,
    input  logic                allow,
    input  logic [TGT_W-1:0]    hit_tgt,
    output ibp_pkg::ctl_state_e state,
    output logic                pred_valid,
    output logic [TGT_W-1:0]    pred_target
);
    import ibp_pkg::*;

    ctl_state_e nxt;
    logic       grant;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt   = state;
        grant = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (train_ok && !barrier) begin
                    nxt = ST_LIVE;
                end
            end
            ST_LIVE: begin
                grant = lk_fire && allow && !barrier;
                if (barrier) begin
                    nxt = ST_EMPTY;
                end
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_target <= '0;
        end else if (grant) begin
            pred_valid  <= 1'b1;
            pred_target <= hit_tgt;
        end else begin
            pred_valid  <= 1'b0;
            pred_target <= '0;
        end
    end

    // R9: a granted prediction was looked up while the table was live
    p_grant_needs_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> ($past(state) == ST_LIVE));

endmodule

// File: rtl/modetag_ibp.sv
module modetag_ibp #(
    parameter int ENTRIES    = 16,
    parameter int TAG_W      = 8,
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int THREADS    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [PC_W-1:0]            lk_pc,
    input  logic [1:0]                 lk_class,
    input  logic [$clog2(THREADS)-1:0] lk_tid,
    input  logic [1:0]                 lk_mode,
    input  logic                       tr_valid,
    input  logic [PC_W-1:0]            tr_pc,
    input  logic [PC_W-1:0]            tr_target,
    input  logic [1:0]                 tr_class,
    input  logic [$clog2(THREADS)-1:0] tr_tid,
    input  logic [1:0]                 tr_mode,
    input  logic [THREADS-1:0]         restrict_spec,
    input  logic [THREADS-1:0]         iso_thread,
    input  logic [THREADS-1:0]         barrier_cmd,
    output logic                       pred_valid,
    output logic [PC_W-1:0]            pred_target
);
    import ibp_pkg::*;

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int TID_W  = $clog2(THREADS);
    localparam int TAG_LO = ALIGN_BITS + IDX_W;
    localparam int TAG_HI = TAG_LO + TAG_W;

    logic [IDX_W-1:0]   lk_idx, tr_idx;
    logic [TAG_W-1:0]   lk_tag, tr_tag;
    logic               barrier_any, train_ok, lk_fire, allow;
    logic               rd_valid;
    logic [TAG_W-1:0]   rd_tag;
    logic [PC_W-1:0]    rd_tgt;
    logic [1:0]         rd_mode;
    logic [TID_W-1:0]   rd_tid;
    logic [ENTRIES-1:0] valid_vec;
    ctl_state_e         state;
    logic               unused_pc_bits;

    assign lk_idx      = lk_pc[ALIGN_BITS +: IDX_W];
    assign tr_idx      = tr_pc[ALIGN_BITS +: IDX_W];
    assign lk_tag      = lk_pc[TAG_LO +: TAG_W];
    assign tr_tag      = tr_pc[TAG_LO +: TAG_W];
    assign barrier_any = |barrier_cmd;
    assign train_ok    = tr_valid && class_ok(tr_class) && !barrier_any;
    assign lk_fire     = lk_valid && class_ok(lk_class);

    assign unused_pc_bits = ^{lk_pc[ALIGN_BITS-1:0], tr_pc[ALIGN_BITS-1:0],
                              lk_pc[PC_W-1:TAG_HI], tr_pc[PC_W-1:TAG_HI]};

    ibp_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .TGT_W   (PC_W),
        .TID_W   (TID_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (barrier_any),
        .wr_en     (train_ok),
        .wr_idx    (tr_idx),
        .wr_tag    (tr_tag),
        .wr_tgt    (tr_target),
        .wr_mode   (tr_mode),
        .wr_tid    (tr_tid),
        .rd_idx    (lk_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_tgt    (rd_tgt),
        .rd_mode   (rd_mode),
        .rd_tid    (rd_tid),
        .valid_vec (valid_vec)
    );

    ibp_filter #(
        .TAG_W   (TAG_W),
        .THREADS (THREADS)
    ) u_filter (
        .ent_valid    (rd_valid),
        .ent_tag      (rd_tag),
        .ent_mode     (rd_mode),
        .ent_tid      (rd_tid),
        .lk_tag       (lk_tag),
        .lk_mode      (lk_mode),
        .lk_tid       (lk_tid),
        .restrict_vec (restrict_spec),
        .iso_vec      (iso_thread),
        .allow        (allow)
    );

    ibp_ctrl #(
        .TGT_W (PC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .barrier     (barrier_any),
        .train_ok    (train_ok),
        .lk_fire     (lk_fire),
        .allow       (allow),
        .hit_tgt     (rd_tgt),
        .state       (state),
        .pred_valid  (pred_valid),
        .pred_target (pred_target)
    );

    // R4: non-eligible lookups never predict
    p_ineligible_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_class == BC_NONE) |=> !pred_valid);

    // R9: a lookup in a barrier cycle never predicts
    p_barrier_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        barrier_any |=> !pred_valid);

    // R9: the controller reports EMPTY only when the table holds nothing
    p_empty_means_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (valid_vec == '0));

    // R5: restricted lookups never use lower-ranked training
    p_restrict_rank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && restrict_spec[lk_tid] && rd_valid &&
         (mode_rank(rd_mode) < mode_rank(lk_mode))) |=> !pred_valid);

    // R7: isolated lookups never use the sibling's training
    p_isolate_sibling_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && iso_thread[lk_tid] && rd_valid && (rd_tid != lk_tid))
        |=> !pred_valid);

    // R11: idle output carries a zero target
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (pred_target == '0));

endmodule

// File: tb/sim_modetag_ibp.sv
module sim_modetag_ibp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_class = '0;
    logic        lk_tid = 1'b0;
    logic [1:0]  lk_mode = '0;
    logic        tr_valid = 1'b0;
    logic [31:0] tr_pc = '0;
    logic [31:0] tr_target = '0;
    logic [1:0]  tr_class = '0;
    logic        tr_tid = 1'b0;
    logic [1:0]  tr_mode = '0;
    logic [1:0]  restrict_spec = '0;
    logic [1:0]  iso_thread = '0;
    logic [1:0]  barrier_cmd = '0;
    logic        pred_valid;
    logic [31:0] pred_target;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    modetag_ibp u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_class(lk_class),
        .lk_tid(lk_tid), .lk_mode(lk_mode),
        .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_target(tr_target),
        .tr_class(tr_class), .tr_tid(tr_tid), .tr_mode(tr_mode),
        .restrict_spec(restrict_spec), .iso_thread(iso_thread),
        .barrier_cmd(barrier_cmd),
        .pred_valid(pred_valid), .pred_target(pred_target)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        tr_do;
        logic [1:0]  tr_cls;
        logic [31:0] tr_pc;
        logic [31:0] tr_tgt;
        logic        tr_tid;
        logic [1:0]  tr_mode;
        logic [31:0] lk_pc;
        logic [1:0]  lk_cls;
        logic        lk_tid;
        logic [1:0]  lk_mode;
        logic [1:0]  rs;
        logic [1:0]  iso;
        logic        exp_v;
        logic [31:0] exp_t;
    } vec_t;

    // Modes: 0 host-sup, 1 host-user, 2 guest-sup, 3 guest-user. Classes: 1 call, 2 jump, 3 return.
    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        // R2 basic hit, thread 0 host-sup
        '{4'd2, 1'b1, 2'd1, 32'h104, 32'hAAAA0000, 1'b0, 2'd0, 32'h104, 2'd1, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1, 32'hAAAA0000},
        // R3 same index, other tag
        '{4'd3, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h144, 2'd1, 1'b0, 2'd0, 2'b00, 2'b00, 1'b0, 32'h0},
        // R6 guest-user training used by host-sup with restrict clear
        '{4'd6, 1'b1, 2'd2, 32'h208, 32'hBBBB0010, 1'b0, 2'd3, 32'h208, 2'd2, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1, 32'hBBBB0010},
        // R5 same entry blocked under restrict
        '{4'd5, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h208, 2'd2, 1'b0, 2'd0, 2'b01, 2'b00, 1'b0, 32'h0},
        // R5 equal rank still predicts
        '{4'd5, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h208, 2'd2, 1'b0, 2'd3, 2'b01, 2'b00, 1'b1, 32'hBBBB0010},
        // R5 host-user training used by guest-sup (higher to lower)
        '{4'd5, 1'b1, 2'd1, 32'h30C, 32'hCCCC0020, 1'b1, 2'd1, 32'h30C, 2'd1, 1'b1, 2'd2, 2'b10, 2'b00, 1'b1, 32'hCCCC0020},
        // R5 host-user training blocked for host-sup
        '{4'd5, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h30C, 2'd1, 1'b1, 2'd0, 2'b10, 2'b00, 1'b0, 32'h0},
        // R5 guest-sup ranks below host-user
        '{4'd5, 1'b1, 2'd1, 32'h410, 32'hDDDD0030, 1'b0, 2'd2, 32'h410, 2'd1, 1'b0, 2'd1, 2'b01, 2'b00, 1'b0, 32'h0},
        // R8 restrict of thread 1 does not touch thread 0
        '{4'd8, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h410, 2'd1, 1'b0, 2'd1, 2'b10, 2'b00, 1'b1, 32'hDDDD0030},
        // R7 isolation blocks sibling training
        '{4'd7, 1'b1, 2'd2, 32'h514, 32'hEEEE0040, 1'b1, 2'd0, 32'h514, 2'd2, 1'b0, 2'd0, 2'b00, 2'b01, 1'b0, 32'h0},
        // R7 isolation clear shares
        '{4'd7, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h514, 2'd2, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1, 32'hEEEE0040},
        // R8 isolation of thread 1 does not touch thread 0
        '{4'd8, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h514, 2'd2, 1'b0, 2'd0, 2'b00, 2'b10, 1'b1, 32'hEEEE0040},
        // R7 own-thread training passes isolation
        '{4'd7, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h514, 2'd2, 1'b1, 2'd0, 2'b00, 2'b10, 1'b1, 32'hEEEE0040},
        // R3 overwrite index 1 with a new tag, old address misses
        '{4'd3, 1'b1, 2'd1, 32'h1104, 32'h12345678, 1'b0, 2'd0, 32'h104, 2'd1, 1'b0, 2'd0, 2'b00, 2'b00, 1'b0, 32'h0},
        // R3 new address hits
        '{4'd3, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h1104, 2'd1, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1, 32'h12345678},
        // R4 non-eligible lookup
        '{4'd4, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0, 2'd0, 32'h1104, 2'd0, 1'b0, 2'd0, 2'b00, 2'b00, 1'b0, 32'h0},
        // R4 non-eligible training ignored
        '{4'd4, 1'b1, 2'd0, 32'h1104, 32'h0BADBAD0, 1'b0, 2'd0, 32'h1104, 2'd2, 1'b0, 2'd0, 2'b00, 2'b00, 1'b1, 32'h12345678},
        // R2 return class, thread 1 guest-user
        '{4'd2, 1'b1, 2'd3, 32'h618, 32'h600DF00D, 1'b1, 2'd3, 32'h618, 2'd3, 1'b1, 2'd3, 2'b11, 2'b11, 1'b1, 32'h600DF00D}
    };

    task automatic check(input string tag, input logic ev, input logic [31:0] et);
        checks++;
        if (pred_valid !== ev || pred_target !== et) begin
            failures++;
            $display("FAIL %s: valid=%0b target=%h expected valid=%0b target=%h",
                     tag, pred_valid, pred_target, ev, et);
        end
    endtask

    task automatic drive_lookup(input logic [31:0] pc, input logic [1:0] cls,
                                input logic tid, input logic [1:0] md);
        lk_valid = 1'b1; lk_pc = pc; lk_class = cls; lk_tid = tid; lk_mode = md;
    endtask

    task automatic drive_train(input logic [31:0] pc, input logic [31:0] tgt,
                               input logic [1:0] cls, input logic tid, input logic [1:0] md);
        tr_valid = 1'b1; tr_pc = pc; tr_target = tgt; tr_class = cls; tr_tid = tid; tr_mode = md;
    endtask

    task automatic idle_inputs();
        lk_valid = 1'b0; tr_valid = 1'b0; barrier_cmd = '0;
        restrict_spec = '0; iso_thread = '0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 1'b0, 32'h0);
        drive_lookup(32'h104, 2'd1, 1'b0, 2'd0);
        @(negedge clk);
        check("R1 lookup on empty table", 1'b0, 32'h0);
        idle_inputs();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (VT[i].tr_do)
                drive_train(VT[i].tr_pc, VT[i].tr_tgt, VT[i].tr_cls, VT[i].tr_tid, VT[i].tr_mode);
            @(negedge clk);
            tr_valid = 1'b0;
            restrict_spec = VT[i].rs;
            iso_thread = VT[i].iso;
            drive_lookup(VT[i].lk_pc, VT[i].lk_cls, VT[i].lk_tid, VT[i].lk_mode);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].exp_v, VT[i].exp_t);
            idle_inputs();
        end

        // R10: training and lookup of one entry in the same cycle
        @(negedge clk);
        drive_train(32'h71C, 32'h77770070, 2'd1, 1'b0, 2'd0);
        drive_lookup(32'h71C, 2'd1, 1'b0, 2'd0);
        @(negedge clk);
        check("R10 same-cycle lookup sees old contents", 1'b0, 32'h0);
        tr_valid = 1'b0;
        @(negedge clk);
        check("R10 following lookup sees update", 1'b1, 32'h77770070);
        idle_inputs();

        // R9: barrier from thread 1, lookup in the same cycle
        @(negedge clk);
        drive_lookup(32'h1104, 2'd1, 1'b0, 2'd0);
        barrier_cmd = 2'b10;
        @(negedge clk);
        check("R9 lookup in barrier cycle", 1'b0, 32'h0);
        barrier_cmd = 2'b00;
        drive_lookup(32'h618, 2'd3, 1'b1, 2'd3);
        @(negedge clk);
        check("R9 entry cleared by barrier", 1'b0, 32'h0);
        drive_lookup(32'h71C, 2'd1, 1'b0, 2'd0);
        @(negedge clk);
        check("R9 second entry cleared (R11 zero target)", 1'b0, 32'h0);
        idle_inputs();

        // R9: training in the barrier cycle is dropped (barrier from thread 0)
        @(negedge clk);
        drive_train(32'h820, 32'h88880080, 2'd2, 1'b0, 2'd0);
        barrier_cmd = 2'b01;
        @(negedge clk);
        idle_inputs();
        drive_lookup(32'h820, 2'd2, 1'b0, 2'd0);
        @(negedge clk);
        check("R9 training in barrier cycle discarded", 1'b0, 32'h0);
        idle_inputs();

        // R9: retraining after the barrier works again
        @(negedge clk);
        drive_train(32'h820, 32'h88880080, 2'd2, 1'b0, 2'd0);
        @(negedge clk);
        tr_valid = 1'b0;
        drive_lookup(32'h820, 2'd2, 1'b0, 2'd0);
        @(negedge clk);
        check("R9 retrain after barrier", 1'b1, 32'h88880080);
        idle_inputs();
        @(negedge clk);
        check("R11 idle after lookup ends", 1'b0, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule